// File: doc/BRIEF.md
# Repeat-Loop Clock Pattern Sequencer

This block runs a small program that drives a detector's clocking. The program lives in an internal dual-port memory, which is filled through a simple write port. It is a chain of two-word records. A group record sets how many step records follow it, how many times the whole group runs, and what happens once the group is done. The sequencer can stop, fall through to the next group record, go back to address 0, or jump to one of 16 pages. Each step record names a pattern block, gives a repeat count and gives a pixel code.

While the sequencer runs, every pixel-clock tick produces a pixel clock for the downstream processors. When a step is ready and the pattern generator is not busy, the tick also carries one pattern-block start and the step's pixel code. A tick that falls during a record fetch, or while the pattern generator is busy, carries the ignore code and no start. Execution begins at page 0 on a start pulse and ends either on a stop pulse or when the program reaches a halt action. After a halt, a halted flag stays set until the next start.

Top module: `clkpat_seq`

## Requirements
- R1: After reset, running, halted, pix_clk and pat_start are all 0.
- R2: A start pulse clears halted, sets running and begins fetching the group record at address 0. If stop and start arrive together, stop takes priority.
- R3: A step record holds two words. Word 0 carries the pixel code in bits 14:12 and the repeat count minus one in bits 11:0. Word 1 carries the pattern-block address. The step is invoked repeat times on consecutive issuing ticks. Each invocation raises pat_start for that tick, with pat_addr set to the pattern-block address and pix_code set to the step's code.
- R4: A group record holds two words. Word 0 carries the action in bits 13:12 and the step count minus one in bits 11:0. Word 1 carries the page in bits 15:12 and the group repeat count minus one in bits 11:0. The steps that follow the record run in address order, and the whole run of steps is repeated the stated number of times.
- R5: Action 0 (halt) ends the program after the group's last invocation. The block then has running=0 and halted=1, and produces no pix_clk until the next start.
- R6: Action 1 (continue) fetches the next group record from the address just after the group's last step record.
- R7: Action 2 (restart) fetches the next group record from address 0.
- R8: Action 3 (jump) fetches the next group record from page × (memory depth / 16). The default depth is 4096 words, which gives 256 words per page.
- R9: While running, every tick raises pix_clk. A tick with no invocation, such as one during a record fetch, carries pix_code 0 (ignore). Pixel codes: 0 ignore, 1 valid, 2 overclock, 3 hsync, 4 vsync.
- R10: A tick that arrives while pat_busy is high issues no invocation. The pending invocation is issued on the next tick at which pat_busy is low.
- R11: A stop pulse returns the block to idle at once, leaving halted at 0. Later ticks produce no pix_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | 12 | Program memory write address |
| prog_data | input | 16 | Program memory write data |
| start | input | 1 | Begin execution at page 0 |
| stop | input | 1 | Abort execution |
| tick | input | 1 | Pixel-clock tick (one-cycle enable) |
| pat_busy | input | 1 | Pattern generator still busy |
| pat_start | output | 1 | Start of one pattern-block invocation |
| pat_addr | output | 16 | Pattern-block address of the current step |
| pix_clk | output | 1 | Pixel clock to downstream processors |
| pix_code | output | 3 | Pixel code that goes with pix_clk |
| running | output | 1 | Sequencer active |
| halted | output | 1 | Program ended with a halt action |

## Verification
The main pattern is one program that combines a repeated two-step group, a single-step group with a repeat count of three, a page jump and a halt. Its invocation stream is compared tick by tick with the expected list. This check tells apart a wrong step repeat, a wrong group repeat, a continue that lands on the wrong address and a jump to the wrong page. The same program is run again with the last group rewritten to restart. The tick after the final step must then replay the first step, which separates restart from halt. Separate patterns place a tick inside a fetch and a tick under pat_busy, to show that the pixel clock runs without an invocation. A further pattern applies stop in the middle of the program.

// File: rtl/clkpat_seq.sv
module clkpat_seq #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 12,
  parameter int PAGES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [WORD_W-1:0] prog_data,
  input  logic              start,
  input  logic              stop,
  input  logic              tick,
  input  logic              pat_busy,
  output logic              pat_start,
  output logic [WORD_W-1:0] pat_addr,
  output logic              pix_clk,
  output logic [2:0]        pix_code,
  output logic              running,
  output logic              halted
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = $clog2(PAGES);
  localparam int OFS_W = ADDR_W - PG_W;

  typedef enum logic [2:0] {S_IDLE, S_HA, S_HB, S_HC, S_CA, S_CB, S_CC, S_RUN} st_t;
  st_t st;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdata;
  logic [ADDR_W-1:0] pc, grp_base, raddr;
  logic [1:0]        act;
  logic [PG_W-1:0]   page;
  logic [CNT_W-1:0]  cnt_m1, cpl_left, grp_left, rep_left;
  logic [2:0]        code;
  logic [WORD_W-1:0] paddr;
  logic              issue;

  assign raddr     = (st == S_HB || st == S_CB) ? pc + ADDR_W'(1) : pc;
  assign issue     = tick && st == S_RUN && !pat_busy;
  assign running   = st != S_IDLE;
  assign pix_clk   = tick && running;
  assign pat_start = issue;
  assign pat_addr  = paddr;
  assign pix_code  = issue ? code : 3'd0;

  always_ff @(posedge clk) begin
    if (prog_we) mem[prog_addr] <= prog_data;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; grp_base <= '0; act <= '0; page <= '0;
      cnt_m1 <= '0; cpl_left <= '0; grp_left <= '0; rep_left <= '0;
      code <= '0; paddr <= '0; halted <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE;
    end else if (start) begin
      st <= S_HA; pc <= '0; halted <= 1'b0;
    end else begin
      case (st)
        S_HA: st <= S_HB;
        S_HB: begin
          act    <= rdata[CNT_W+1:CNT_W];
          cnt_m1 <= rdata[CNT_W-1:0];
          st     <= S_HC;
        end
        S_HC: begin
          page     <= rdata[CNT_W+PG_W-1:CNT_W];
          grp_left <= rdata[CNT_W-1:0];
          cpl_left <= cnt_m1;
          pc       <= pc + ADDR_W'(2);
          grp_base <= pc + ADDR_W'(2);
          st       <= S_CA;
        end
        S_CA: st <= S_CB;
        S_CB: begin
          code     <= rdata[CNT_W+2:CNT_W];
          rep_left <= rdata[CNT_W-1:0];
          st       <= S_CC;
        end
        S_CC: begin
          paddr <= rdata;
          st    <= S_RUN;
        end
        S_RUN: if (issue) begin
          if (rep_left != '0) rep_left <= rep_left - 1'b1;
          else if (cpl_left != '0) begin
            cpl_left <= cpl_left - 1'b1;
            pc <= pc + ADDR_W'(2);
            st <= S_CA;
          end else if (grp_left != '0) begin
            grp_left <= grp_left - 1'b1;
            cpl_left <= cnt_m1;
            pc <= grp_base;
            st <= S_CA;
          end else begin
            case (act)
              2'd0: begin st <= S_IDLE; halted <= 1'b1; end
              2'd1: begin pc <= pc + ADDR_W'(2); st <= S_HA; end
              2'd2: begin pc <= '0; st <= S_HA; end
              default: begin pc <= {page, OFS_W'(0)}; st <= S_HA; end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module clkpat_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop,
  input logic       pat_busy,
  input logic       pat_start,
  input logic       pix_clk,
  input logic [2:0] pix_code,
  input logic       running,
  input logic       halted
);
  assert_issue_clk_R3: assert property (@(posedge clk) disable iff (!rst_n) pat_start |-> pix_clk);
  assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n) !running |-> !pix_clk);
  assert_halt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !running);
  assert_halt_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n) $rose(halted) |-> $past(running));
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n) pat_busy |-> !pat_start);
  assert_ignore_code_R9: assert property (@(posedge clk) disable iff (!rst_n) (pix_clk && !pat_start) |-> pix_code == 3'd0);
  assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n) stop |=> !running && !halted);
endmodule

bind clkpat_seq clkpat_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .pat_busy(pat_busy), .pat_start(pat_start),
  .pix_clk(pix_clk), .pix_code(pix_code), .running(running), .halted(halted)
);

// File: tb/sim_clkpat_seq.sv
module sim_clkpat_seq;
  logic clk = 0, rst_n = 0, prog_we = 0, start = 0, stop = 0, tick = 0, pat_busy = 0;
  logic [11:0] prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic pat_start, pix_clk, running, halted;
  logic [15:0] pat_addr;
  logic [2:0] pix_code;
  int checks = 0, errors = 0;
  logic s_ps, s_pc;
  logic [2:0] s_code;
  logic [15:0] s_addr;

  always #5 clk = ~clk;

  clkpat_seq u0 (.clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .start(start), .stop(stop), .tick(tick), .pat_busy(pat_busy),
    .pat_start(pat_start), .pat_addr(pat_addr), .pix_clk(pix_clk), .pix_code(pix_code),
    .running(running), .halted(halted));

  // expected invocation stream: {code, pattern address}
  localparam logic [18:0] EXP [10] = '{
    {3'd4, 16'h000A}, {3'd1, 16'h000B}, {3'd1, 16'h000B},
    {3'd4, 16'h000A}, {3'd1, 16'h000B}, {3'd1, 16'h000B},
    {3'd2, 16'h000C}, {3'd2, 16'h000C}, {3'd2, 16'h000C},
    {3'd3, 16'h000D}};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk); prog_we = 1; prog_addr = 12'(a); prog_data = d;
    @(negedge clk); prog_we = 0;
  endtask

  task automatic hdr(int a, int act, int cnt_m1, int pg, int rep_m1);
    wr(a, {2'b0, 2'(act), 12'(cnt_m1)});
    wr(a + 1, {4'(pg), 12'(rep_m1)});
  endtask

  task automatic cpl(int a, int code, int rep_m1, logic [15:0] pa);
    wr(a, {1'b0, 3'(code), 12'(rep_m1)});
    wr(a + 1, pa);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1; #1;
    s_ps = pat_start; s_pc = pix_clk; s_code = pix_code; s_addr = pat_addr;
    @(posedge clk); #1 tick = 0;
    repeat (8) @(posedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 running", running, 0);
    check("R1 halted", halted, 0);
    check("R1 pix_clk", pix_clk, 0);
    check("R1 pat_start", pat_start, 0);
    @(negedge clk); rst_n = 1;

    hdr(0, 1, 1, 0, 1);          // continue, 2 steps, group x2
    cpl(2, 4, 0, 16'h000A);
    cpl(4, 1, 1, 16'h000B);
    hdr(6, 3, 0, 3, 0);          // jump to page 3
    cpl(8, 2, 2, 16'h000C);
    hdr(768, 0, 0, 0, 0);        // halt
    cpl(770, 3, 0, 16'h000D);

    pulse_start();
    #1 check("R2 running after start", running, 1);
    repeat (8) @(posedge clk);
    for (int i = 0; i < 10; i++) begin
      do_tick();
      check("R3/R4/R6/R8 pat_start", s_ps, 1);
      check("R3/R4/R6/R8 pix_code", s_code, EXP[i][18:16]);
      check("R3/R4/R6/R8 pat_addr", s_addr, EXP[i][15:0]);
    end
    do_tick();
    check("R5 pix_clk after halt", s_pc, 0);
    check("R5 halted", halted, 1);
    check("R5 running", running, 0);

    pulse_start();
    #1 check("R2 halted cleared", halted, 0);
    repeat (8) @(posedge clk);
    pat_busy = 1;
    do_tick();
    pat_busy = 0;
    check("R10 pix_clk while busy", s_pc, 1);
    check("R10 no start while busy", s_ps, 0);
    check("R9 ignore code while busy", s_code, 0);
    do_tick();
    check("R10 deferred start", s_ps, 1);
    check("R10 deferred addr", s_addr, 16'h000A);
    check("R10 deferred code", s_code, 4);
    pulse_stop();
    #1 check("R11 running after stop", running, 0);
    check("R11 halted after stop", halted, 0);
    do_tick();
    check("R11 no pix_clk after stop", s_pc, 0);

    @(negedge clk); start = 1; @(negedge clk); start = 0;
    tick = 1; #1;
    s_ps = pat_start; s_pc = pix_clk; s_code = pix_code;
    @(posedge clk); #1 tick = 0;
    check("R9 pix_clk during fetch", s_pc, 1);
    check("R9 no start during fetch", s_ps, 0);
    check("R9 ignore code during fetch", s_code, 0);
    pulse_stop();

    @(negedge clk); stop = 1; start = 1; @(negedge clk); stop = 0; start = 0;
    #1 check("R2 stop beats start", running, 0);

    hdr(768, 2, 0, 0, 0);        // restart
    pulse_start();
    repeat (8) @(posedge clk);
    for (int i = 0; i < 10; i++) do_tick();
    do_tick();
    check("R7 restart start", s_ps, 1);
    check("R7 restart addr", s_addr, 16'h000A);
    check("R7 restart code", s_code, 4);
    pulse_stop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule